// File: doc/BRIEF.md
# Flash Word-Program Algorithm Engine

This block models the automatic word-program algorithm of a NOR-style flash array behind a simple CPU bus. The bus carries a 16-bit byte address, 16-bit write data, write and read strobes, and a synchronous active-high hardware reset. Software unlocks the engine with three fixed address/data write cycles. The fourth write then supplies the target address and the word to program. The engine runs one timed write into its internal word array. It reports progress only through status bits that appear on the read data bus while it is busy. There is no separate done signal.

Programming can only clear bits. A request for a 1 where the cell already holds a 0 can never finish. In that case the engine runs until a cycle budget expires, raises a timeout flag and waits for a read/reset command. A hardware reset in the middle of a program leaves the target word scrambled. An `erase_all` strobe stands in for erase and sets every word to all ones.

Top module: `flash_prog_engine`

## Requirements
- R1: A program starts only after this write sequence: data low byte 0xAA at address 0xAAAA, then 0x55 at 0x5554, then 0xA0 at 0xAAAA. The next write gives the target address and the 16-bit word.
- R2: If any of the first three cycles has the wrong address or the wrong low data byte, the decoder goes back to idle and no program is started.
- R3: A target address with bit 0 set leaves the array unchanged. From the next cycle on, status reads return bit 5 = 1, bit 6 = 0 and bit 7 = inverse of data bit 7.
- R4: Each program command writes exactly one word, at index addr[IDX_W:1]. Commands may target words in any order, and all other words keep their contents.
- R5: The stored result of a program is the old word ANDed with the new data.
- R6: The engine is busy for PROG_CYCLES cycles. A read sampled in any of the PROG_CYCLES cycles after the fourth write returns status. A later read returns array data.
- R7: The status word has bit 7 = inverse of data bit 7, bit 6 = toggle value and bit 5 = timeout flag; all other bits are 0. The toggle starts at 0 on each program and flips after every status read while busy.
- R8: Every bus write made while the engine is busy is ignored, and the decoder is idle once the engine finishes.
- R9: When the data has a 1 where the old word has a 0, the program never completes. After LIMIT_CYCLES busy cycles bit 5 becomes 1, bit 7 stays inverted and bit 6 stops changing. The array then holds old AND data.
- R10: After a timeout, only a write with low data byte 0xF0 (at any address) returns the engine to reading the array; other writes are ignored. A 0xF0 write in the read state has no effect.
- R11: A hardware reset during a program returns the engine to the read state with read data 0. The target word then holds a value different from old AND data.
- R12: A pulse on `erase_all` sets every word to 0xFFFF.
- R13: After reset the read data output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| bus_addr | input | 16 | Byte address of the bus access |
| bus_wdata | input | 16 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe; data appears on bus_rdata after the next clock edge |
| erase_all | input | 1 | Stub erase: sets all words to 0xFFFF |
| bus_rdata | output | 16 | Registered read data: an array word, or the status word while busy or timed out |

## Verification
The bench builds the engine with WORDS = 16, PROG_CYCLES = 6 and LIMIT_CYCLES = 20. The short program time lets the bench read every busy cycle in turn and follow the status bit toggling cycle by cycle. The short budget brings the timeout edge, the frozen toggle and the flag change within a few dozen reads. Sixteen words allow a program at the lowest and at the highest index, with checks on the neighbours on both sides.

// File: rtl/flash_prog_pkg.sv
package flash_prog_pkg;

    localparam int BUS_AW = 16;
    localparam int BUS_DW = 16;

    localparam logic [BUS_AW-1:0] UNLOCK_ADDR_A = 16'hAAAA;
    localparam logic [BUS_AW-1:0] UNLOCK_ADDR_B = 16'h5554;
    localparam logic [7:0]        KEY_FIRST     = 8'hAA;
    localparam logic [7:0]        KEY_SECOND    = 8'h55;
    localparam logic [7:0]        OP_PROGRAM    = 8'hA0;
    localparam logic [7:0]        OP_READRESET  = 8'hF0;

    typedef logic [BUS_DW-1:0] word_t;

    typedef enum logic [1:0] {
        DEC_IDLE,
        DEC_KEY1,
        DEC_KEY2,
        DEC_ARMED
    } dec_state_e;

    typedef enum logic [1:0] {
        ENG_READ,
        ENG_BUSY,
        ENG_FAIL
    } eng_state_e;

    typedef struct packed {
        logic poll_n;
        logic toggle;
        logic expired;
    } flag_t;

    function automatic word_t status_word(input flag_t f);
        return {8'h00, f.poll_n, f.toggle, f.expired, 5'b00000};
    endfunction

    // Mix a salt into a word; the low mask bit is always set, so the
    // result always differs from the clean word.
    function automatic word_t scramble(input word_t clean, input logic [15:0] salt);
        return clean ^ {salt[14:0], 1'b1};
    endfunction

endpackage

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import flash_prog_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [7:0]        cmd_byte,
    input  logic              eng_idle,
    input  logic              eng_failed,
    output logic              launch,
    output logic              reset_cmd,
    output dec_state_e        dec_state
);

    dec_state_e st, nx;

    always_comb begin
        nx = st;
        if (!eng_idle) begin
            nx = DEC_IDLE;
        end else if (bus_we) begin
            unique case (st)
                DEC_IDLE:  nx = (bus_addr == UNLOCK_ADDR_A && cmd_byte == KEY_FIRST)
                                ? DEC_KEY1 : DEC_IDLE;
                DEC_KEY1:  nx = (bus_addr == UNLOCK_ADDR_B && cmd_byte == KEY_SECOND)
                                ? DEC_KEY2 : DEC_IDLE;
                DEC_KEY2:  nx = (bus_addr == UNLOCK_ADDR_A && cmd_byte == OP_PROGRAM)
                                ? DEC_ARMED : DEC_IDLE;
                DEC_ARMED: nx = DEC_IDLE;
                default:   nx = DEC_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st <= DEC_IDLE;
        else     st <= nx;
    end

    assign launch    = eng_idle && bus_we && (st == DEC_ARMED);
    assign reset_cmd = eng_failed && bus_we && (cmd_byte == OP_READRESET);
    assign dec_state = st;

endmodule

// File: rtl/flash_word_array.sv
module flash_word_array
    import flash_prog_pkg::*;
#(
    parameter  int WORDS = 64,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             erase_all,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  word_t            wr_data,
    input  logic [IDX_W-1:0] rd_idx_bus,
    output word_t            rd_bus,
    input  logic [IDX_W-1:0] rd_idx_tgt,
    output word_t            rd_tgt
);

    word_t cells [WORDS];

    // Non-volatile contents: no reset, only erase and word writes.
    always_ff @(posedge clk) begin
        for (int i = 0; i < WORDS; i++) begin
            if (erase_all)
                cells[i] <= '1;
            else if (wr_en && wr_idx == IDX_W'(i))
                cells[i] <= wr_data;
        end
    end

    assign rd_bus = cells[rd_idx_bus];
    assign rd_tgt = cells[rd_idx_tgt];

endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
    import flash_prog_pkg::*;
#(
    parameter  int WORDS        = 64,
    parameter  int PROG_CYCLES  = 16,
    parameter  int LIMIT_CYCLES = 200,
    localparam int IDX_W        = $clog2(WORDS),
    localparam int CNT_W        = $clog2(LIMIT_CYCLES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             launch,
    input  logic [IDX_W-1:0] launch_idx,
    input  logic             launch_odd,
    input  word_t            launch_data,
    input  logic             reset_cmd,
    input  logic             bus_re,
    input  word_t            old_word,
    output eng_state_e       eng_state,
    output logic [IDX_W-1:0] tgt_idx,
    output logic             need_fail,
    output logic             tog,
    output logic             wr_en,
    output word_t            wr_data,
    output word_t            status
);

    eng_state_e       st;
    logic [CNT_W-1:0] cnt;
    word_t            tgt_data;
    logic             fin_ok, fin_bad;
    word_t            merged;
    flag_t            flags;

    assign merged    = old_word & tgt_data;
    assign need_fail = |(tgt_data & ~old_word);
    assign fin_ok    = (st == ENG_BUSY) && !need_fail && (cnt == CNT_W'(PROG_CYCLES - 1));
    assign fin_bad   = (st == ENG_BUSY) &&  need_fail && (cnt == CNT_W'(LIMIT_CYCLES - 1));

    // A reset that lands on a busy cycle leaves the target word scrambled.
    assign wr_en   = (st == ENG_BUSY) && (rst || fin_ok || fin_bad);
    assign wr_data = rst ? scramble(merged, 16'(cnt)) : merged;

    assign flags.poll_n  = ~tgt_data[7];
    assign flags.toggle  = tog;
    assign flags.expired = (st == ENG_FAIL);
    assign status        = status_word(flags);

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ENG_READ;
            cnt      <= '0;
            tog      <= 1'b0;
            tgt_idx  <= '0;
            tgt_data <= '0;
        end else begin
            unique case (st)
                ENG_READ: begin
                    if (launch) begin
                        tgt_idx  <= launch_idx;
                        tgt_data <= launch_data;
                        cnt      <= '0;
                        tog      <= 1'b0;
                        st       <= launch_odd ? ENG_FAIL : ENG_BUSY;
                    end
                end
                ENG_BUSY: begin
                    cnt <= cnt + 1'b1;
                    if (bus_re) tog <= ~tog;
                    if (fin_ok)       st <= ENG_READ;
                    else if (fin_bad) st <= ENG_FAIL;
                end
                ENG_FAIL: begin
                    if (reset_cmd) st <= ENG_READ;
                end
                default: st <= ENG_READ;
            endcase
        end
    end

    assign eng_state = st;

endmodule

// File: rtl/flash_prog_engine.sv
module flash_prog_engine
    import flash_prog_pkg::*;
#(
    parameter int WORDS        = 64,
    parameter int PROG_CYCLES  = 16,
    parameter int LIMIT_CYCLES = 200
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] bus_addr,
    input  logic [15:0] bus_wdata,
    input  logic        bus_we,
    input  logic        bus_re,
    input  logic        erase_all,
    output logic [15:0] bus_rdata
);

    localparam int IDX_W = $clog2(WORDS);

    eng_state_e       eng_state;
    dec_state_e       dec_state;
    logic             launch, launch_odd, reset_cmd;
    logic [IDX_W-1:0] bus_idx, tgt_idx;
    logic             need_fail, tog;
    logic             mem_we;
    word_t            mem_wdata, tgt_old, bus_word, status;

    assign bus_idx    = bus_addr[IDX_W:1];
    assign launch_odd = bus_addr[0];

    flash_cmd_decoder u_dec (
        .clk        (clk),
        .rst        (rst),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .cmd_byte   (bus_wdata[7:0]),
        .eng_idle   (eng_state == ENG_READ),
        .eng_failed (eng_state == ENG_FAIL),
        .launch     (launch),
        .reset_cmd  (reset_cmd),
        .dec_state  (dec_state)
    );

    flash_prog_seq #(
        .WORDS        (WORDS),
        .PROG_CYCLES  (PROG_CYCLES),
        .LIMIT_CYCLES (LIMIT_CYCLES)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .launch      (launch),
        .launch_idx  (bus_idx),
        .launch_odd  (launch_odd),
        .launch_data (bus_wdata),
        .reset_cmd   (reset_cmd),
        .bus_re      (bus_re),
        .old_word    (tgt_old),
        .eng_state   (eng_state),
        .tgt_idx     (tgt_idx),
        .need_fail   (need_fail),
        .tog         (tog),
        .wr_en       (mem_we),
        .wr_data     (mem_wdata),
        .status      (status)
    );

    flash_word_array #(
        .WORDS (WORDS)
    ) u_mem (
        .clk        (clk),
        .erase_all  (erase_all),
        .wr_en      (mem_we),
        .wr_idx     (tgt_idx),
        .wr_data    (mem_wdata),
        .rd_idx_bus (bus_idx),
        .rd_bus     (bus_word),
        .rd_idx_tgt (tgt_idx),
        .rd_tgt     (tgt_old)
    );

    always_ff @(posedge clk) begin
        if (rst)
            bus_rdata <= '0;
        else if (bus_re)
            bus_rdata <= (eng_state == ENG_READ) ? bus_word : status;
    end

endmodule

// File: rtl/flash_prog_chk.sv
module flash_prog_chk
    import flash_prog_pkg::*;
#(
    parameter  int PROG_CYCLES  = 16,
    parameter  int LIMIT_CYCLES = 200,
    localparam int CW           = $clog2(LIMIT_CYCLES + 1)
) (
    input logic       clk,
    input logic       rst,
    input logic       bus_re,
    input logic       dq5_out,
    input eng_state_e eng_state,
    input dec_state_e dec_state,
    input logic       launch,
    input logic       launch_odd,
    input logic       mem_we,
    input word_t      mem_wdata,
    input word_t      tgt_old,
    input logic       need_fail,
    input logic       tog
);

    logic [CW-1:0] run;

    always_ff @(posedge clk) begin
        if (rst)                       run <= '0;
        else if (eng_state == ENG_BUSY) run <= run + 1'b1;
        else                           run <= '0;
    end

    // R5
    clear_only_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> ((mem_wdata & ~tgt_old) == '0));

    // R3
    odd_reject_chk: assert property (@(posedge clk) disable iff (rst)
        (launch && launch_odd) |=> (eng_state == ENG_FAIL));

    // R6
    prog_len_chk: assert property (@(posedge clk) disable iff (rst)
        (eng_state == ENG_BUSY && !need_fail && run == CW'(PROG_CYCLES - 1))
        |=> (eng_state == ENG_READ));

    // R6
    no_early_done_chk: assert property (@(posedge clk) disable iff (rst)
        (eng_state == ENG_BUSY && run < CW'(PROG_CYCLES - 1))
        |=> (eng_state == ENG_BUSY));

    // R9
    no_early_timeout_chk: assert property (@(posedge clk) disable iff (rst)
        (eng_state == ENG_BUSY && need_fail && run < CW'(LIMIT_CYCLES - 1))
        |=> (eng_state == ENG_BUSY));

    // R9
    toggle_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (eng_state == ENG_FAIL) |=> $stable(tog));

    // R9
    dq5_out_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_re && eng_state == ENG_FAIL) |=> dq5_out);

    // R8
    busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (eng_state != ENG_READ) |=> (dec_state == DEC_IDLE));

endmodule

bind flash_prog_engine flash_prog_chk #(
    .PROG_CYCLES  (PROG_CYCLES),
    .LIMIT_CYCLES (LIMIT_CYCLES)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_re     (bus_re),
    .dq5_out    (bus_rdata[5]),
    .eng_state  (eng_state),
    .dec_state  (dec_state),
    .launch     (launch),
    .launch_odd (launch_odd),
    .mem_we     (mem_we),
    .mem_wdata  (mem_wdata),
    .tgt_old    (tgt_old),
    .need_fail  (need_fail),
    .tog        (tog)
);

// File: tb/test_flash_prog_engine.sv
`timescale 1ns/1ps
module test_flash_prog_engine;

    localparam int WORDS = 16;
    localparam int PROG  = 6;
    localparam int LIMIT = 20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic        erase_all = 1'b0;
    logic [15:0] bus_rdata;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    flash_prog_engine #(
        .WORDS        (WORDS),
        .PROG_CYCLES  (PROG),
        .LIMIT_CYCLES (LIMIT)
    ) i_flash_prog_engine (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_re    (bus_re),
        .erase_all (erase_all),
        .bus_rdata (bus_rdata)
    );

    typedef struct {
        logic [15:0] val;
        bit          differ;
        string       tag;
    } exp_t;

    exp_t sb[$];
    logic rd_seen = 1'b0;

    // Monitor: a read sampled at a rising edge is compared at the next falling edge.
    always @(posedge clk) rd_seen <= bus_re;

    always @(negedge clk) begin
        if (rd_seen) begin
            if (sb.size() == 0) begin
                bad++;
                $display("FAIL unexpected read result actual=%h expected=none", bus_rdata);
            end else begin
                exp_t e;
                e = sb.pop_front();
                total++;
                if (e.differ ? (bus_rdata === e.val) : (bus_rdata !== e.val)) begin
                    bad++;
                    $display("FAIL %s actual=%h expected=%s%h", e.tag, bus_rdata,
                             e.differ ? "not " : "", e.val);
                end
            end
        end
    end

    function automatic logic [15:0] stat(input bit poll_n, input bit tg, input bit tmo);
        return {8'h00, poll_n, tg, tmo, 5'b00000};
    endfunction

    // Driver tasks: called at a falling edge, they hold the bus for one cycle.
    task automatic wr(input logic [15:0] a, input logic [15:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, input logic [15:0] v, input bit differ, input string tag);
        exp_t e;
        e.val = v; e.differ = differ; e.tag = tag;
        sb.push_back(e);
        bus_re = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_re = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic prog(input logic [15:0] a, input logic [15:0] d);
        wr(16'hAAAA, 16'h00AA);
        wr(16'h5554, 16'h0055);
        wr(16'hAAAA, 16'h00A0);
        wr(a, d);
    endtask

    task automatic check_now(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R13: reset state
        check_now("R13", bus_rdata, 16'h0000);
        rst = 1'b0;
        @(negedge clk);

        // R12: erase sets every word
        erase_all = 1'b1; @(negedge clk); erase_all = 1'b0;
        rd(16'h0000, 16'hFFFF, 0, "R12");
        rd(16'h001E, 16'hFFFF, 0, "R12");

        // R1 R6 R7: normal program, status read in every busy cycle
        prog(16'h0004, 16'h1234);
        for (int i = 0; i < PROG; i++)
            rd(16'h0004, stat(1'b1, i[0], 1'b0), 0, "R6 R7 status while busy");
        rd(16'h0004, 16'h1234, 0, "R1 R6 data after completion");

        // R2: wrong second address, then wrong third data
        wr(16'hAAAA, 16'h00AA); wr(16'h5550, 16'h0055); wr(16'hAAAA, 16'h00A0);
        wr(16'h0002, 16'h0000);
        rd(16'h0002, 16'hFFFF, 0, "R2 bad unlock address");
        wr(16'hAAAA, 16'h00AA); wr(16'h5554, 16'h0055); wr(16'hAAAA, 16'h0080);
        wr(16'h0002, 16'h0000);
        rd(16'h0002, 16'hFFFF, 0, "R2 bad command byte");

        // R8: a full command while busy is ignored
        prog(16'h000C, 16'hABCD);
        prog(16'h000E, 16'h0000);
        idle(PROG);
        wr(16'h000E, 16'h1111);
        rd(16'h000E, 16'hFFFF, 0, "R8 command during busy ignored");
        rd(16'h000C, 16'hABCD, 0, "R8 busy program completes");

        // R4: highest then lowest index, neighbours untouched
        prog(16'h001E, 16'h5A5A); idle(PROG + 1);
        prog(16'h0000, 16'h0F0F); idle(PROG + 1);
        rd(16'h001E, 16'h5A5A, 0, "R4 top word");
        rd(16'h0000, 16'h0F0F, 0, "R4 bottom word");
        rd(16'h0002, 16'hFFFF, 0, "R4 neighbour above bottom");
        rd(16'h001C, 16'hFFFF, 0, "R4 neighbour below top");

        // R9 R5: 1-over-0 request times out
        prog(16'h0006, 16'h00FF); idle(PROG + 1);
        prog(16'h0006, 16'hFF00);
        for (int i = 0; i < LIMIT + 2; i++) begin
            if (i < LIMIT) rd(16'h0006, stat(1'b1, i[0], 1'b0), 0, "R7 R9 before limit");
            else           rd(16'h0006, stat(1'b1, LIMIT % 2 == 1, 1'b1), 0, "R9 after limit");
        end
        // R10: other writes ignored while timed out
        wr(16'hAAAA, 16'h00AA);
        rd(16'h0000, stat(1'b1, LIMIT % 2 == 1, 1'b1), 0, "R10 non-reset write ignored");
        wr(16'h0000, 16'h00F0);
        rd(16'h0006, 16'h0000, 0, "R5 R10 old AND data after read/reset");
        wr(16'h0000, 16'h00F0);
        rd(16'h0006, 16'h0000, 0, "R10 reset command in read state");
        rd(16'h0000, 16'h0F0F, 0, "R10 reset command in read state");

        // R3: odd address
        prog(16'h0011, 16'h1234);
        rd(16'h0011, stat(1'b1, 1'b0, 1'b1), 0, "R3 odd status");
        rd(16'h0011, stat(1'b1, 1'b0, 1'b1), 0, "R3 odd status no toggle");
        wr(16'h0010, 16'h00F0);
        rd(16'h0010, 16'hFFFF, 0, "R3 array unchanged");

        // R11: hardware reset mid-program
        prog(16'h0008, 16'h1234);
        idle(2);
        rst = 1'b1; @(negedge clk); rst = 1'b0;
        check_now("R11 rdata after reset", bus_rdata, 16'h0000);
        rd(16'h0008, 16'h1234, 1, "R11 aborted word scrambled");
        prog(16'h000A, 16'h4321); idle(PROG + 1);
        rd(16'h000A, 16'h4321, 0, "R11 engine usable after reset");

        idle(3);
        if (sb.size() != 0) begin
            bad++;
            $display("FAIL pending reads actual=%0d expected=0", sb.size());
        end
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            bad++;
            total++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule